// File: doc/BRIEF.md
# Control Endpoint Stage Sequencer

This block follows a device's control transfers on endpoint zero, one token at a time, and chooses the handshake for each token. The serial engine reports every token it decodes: its kind, whether any OUT data was empty, and for a SETUP the eight request bytes. The block answers with ACK, NAK, STALL or no handshake at all one cycle later. It keeps the request as four 16-bit words that the application fetches by index. It refuses to replace them with a later SETUP until all four words have been fetched.

The request is decoded as it is captured. Class and vendor requests go to software, and so do the three standard requests that need application data: descriptor get (code 6), descriptor set (code 7) and frame sync (code 12). All other standard requests are finished by the block itself, with no software step. For a request sent to software, data and status tokens are held off with NAK. They stay held off until software signals that it is ready to move on, and then that it is done. A token in the reverse direction marks the status stage. Software can reject a request, and the block then answers STALL. When the host closes a control read early, the block can pulse a flush to the IN FIFO, so that a packet already queued is not sent.

Top module: `ep0_ctrl_seq`

## Requirements
- R1: After reset, no handshake is issued, the stage output is IDLE, reqPending is low and the register lock is open. The stage codes are IDLE 0, SETUP_HOLD 1, DATA_IN 2, DATA_OUT 3, STATUS_IN 4, STATUS_OUT 5 and STALLED 6.
- R2: Token kinds are SETUP 0, IN 1 and OUT 2, and handshake codes are ACK 0, NAK 1 and STALL 2. Each handshake appears with hsValid for one cycle, in the cycle after the token. A SETUP accepted while the lock is open is answered with ACK. The request bytes are then readable: word i carries byte 2i in bits 7:0 and byte 2i+1 in bits 15:8, with byte 0 in setupData[7:0].
- R3: A request sent to software closes the lock. While the lock is closed, a SETUP gets no handshake and changes neither the stored words nor the stage. The lock opens once every word has been read. A read of the last word in the same cycle as a SETUP does not open the lock for that SETUP.
- R4: A request goes to software when byte 0 bits 6:5 are non-zero, or when byte 1 is 6, 7 or 12. A request sent to software enters SETUP_HOLD and raises reqPending. Any other request leaves the lock open and goes straight to its next stage, with reqPending low.
- R5: In SETUP_HOLD, IN and OUT tokens get NAK. A swReady pulse moves the stage on. If wLength (word 3) is zero, the next stage is STATUS_IN. Otherwise byte 0 bit 7 picks it: 1 gives DATA_IN and 0 gives DATA_OUT.
- R6: In DATA_IN an IN token gets ACK, and in DATA_OUT an OUT token gets ACK.
- R7: An empty OUT during DATA_IN starts STATUS_OUT, and an IN during DATA_OUT starts STATUS_IN. A status token gets NAK until swDone has been seen. After that it gets ACK, the stage returns to IDLE, and statusEvt pulses with the ACK. statusDir is 1 when the status stage ran on an IN token and 0 when it ran on an OUT token.
- R8: A swStall pulse outside IDLE moves the stage to STALLED, where every IN and OUT token gets STALL. An OUT carrying data in DATA_IN or STATUS_OUT also gets STALL and enters STALLED. A SETUP accepted while the lock is open leaves STALLED.
- R9: The empty OUT that ends DATA_IN pulses inFlush for one cycle, alongside its handshake, only while autoFlushEn is high.
- R10: In IDLE, IN and OUT tokens get NAK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tokValid | input | 1 | A token is reported this cycle |
| tokKind | input | 2 | Token kind: 0 SETUP, 1 IN, 2 OUT |
| tokZeroLen | input | 1 | The OUT token carried no data |
| setupData | input | 64 | Request bytes of a SETUP, byte 0 in bits 7:0 |
| rdValid | input | 1 | The application reads one stored word |
| rdIdx | input | 2 | Index of the word being read |
| rdData | output | 16 | Stored word selected by rdIdx |
| swReady | input | 1 | Pulse: software is ready for the data or status stage |
| swDone | input | 1 | Pulse: software has finished the request |
| swStall | input | 1 | Pulse: software rejects the request |
| autoFlushEn | input | 1 | Allow the automatic IN flush on early termination |
| hsValid | output | 1 | A handshake decision is issued |
| hsCode | output | 2 | Handshake: 0 ACK, 1 NAK, 2 STALL |
| stage | output | 3 | Current transfer stage |
| reqPending | output | 1 | A request sent to software is not yet finished |
| inFlush | output | 1 | One-cycle flush pulse to the IN FIFO |
| statusEvt | output | 1 | Status stage completed with ACK |
| statusDir | output | 1 | Direction of that status stage: 1 IN, 0 OUT |

## Verification
The application's read of the last stored word can fall in the same cycle as a new SETUP from the host. The bench provokes this by driving rdValid for word 3 and a SETUP token on the same clock edge. It judges the result by three things: the SETUP gets no handshake, the old word 0 is still readable, and a SETUP sent after that edge is accepted.

// File: rtl/ep0_pkg.sv
package ep0_pkg;
  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_SETUP_HOLD = 3'd1,
    ST_DATA_IN    = 3'd2,
    ST_DATA_OUT   = 3'd3,
    ST_STATUS_IN  = 3'd4,
    ST_STATUS_OUT = 3'd5,
    ST_STALLED    = 3'd6
  } stage_t;

  typedef enum logic [1:0] {
    HS_ACK   = 2'd0,
    HS_NAK   = 2'd1,
    HS_STALL = 2'd2
  } hs_t;

  localparam logic [1:0] TOK_SETUP = 2'd0;
  localparam logic [1:0] TOK_IN    = 2'd1;
  localparam logic [1:0] TOK_OUT   = 2'd2;

  // strobes from control to the setup store
  typedef struct packed {
    logic capture;   // load the request words
    logic preRead;   // mark all words as read (request finished internally)
  } dpStrobe_t;
endpackage

// File: rtl/ep0_setup_store.sv
module ep0_setup_store
  import ep0_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int NUM_WORDS = 4,
  localparam int IDX_W    = $clog2(NUM_WORDS),
  localparam int DATA_W   = WORD_W * NUM_WORDS
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] setupData,
  input  logic              rdValid,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [WORD_W-1:0] rdData,
  output logic              locked,
  output logic              reqDirIn,
  output logic              reqNoData,
  output logic              reqForward
);
  localparam logic [NUM_WORDS-1:0] ALL_READ = '1;

  logic [WORD_W-1:0]    words [NUM_WORDS];
  logic [NUM_WORDS-1:0] readMask;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rstN) begin
        words[w]    <= '0;
        readMask[w] <= 1'b1;
      end else if (strobe.capture) begin
        words[w]    <= setupData[w*WORD_W +: WORD_W];
        readMask[w] <= strobe.preRead;
      end else if (rdValid && rdIdx == IDX_W'(w)) begin
        readMask[w] <= 1'b1;
      end
    end

    AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rstN)
      locked |=> $stable(words[w])) else $error("word overwritten while locked"); // R3
  end

  assign rdData = words[rdIdx];
  assign locked = (readMask != ALL_READ);

  // request decode from the incoming bytes
  logic [7:0] reqType, reqCode;
  assign reqType    = setupData[7:0];
  assign reqCode    = setupData[15:8];
  assign reqDirIn   = reqType[7];
  assign reqNoData  = (setupData[DATA_W-1 -: 16] == 16'd0);
  assign reqForward = (reqType[6:5] != 2'b00) ||
                      (reqCode == 8'd6) || (reqCode == 8'd7) || (reqCode == 8'd12);

  AST_LOCK_ON_FORWARD: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && !strobe.preRead) |=> locked) else $error("lock not closed"); // R4
endmodule

// File: rtl/ep0_stage_ctrl.sv
module ep0_stage_ctrl
  import ep0_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tokValid,
  input  logic [1:0] tokKind,
  input  logic       tokZeroLen,
  input  logic       swReady,
  input  logic       swDone,
  input  logic       swStall,
  input  logic       autoFlushEn,
  input  logic       locked,
  input  logic       reqDirIn,
  input  logic       reqNoData,
  input  logic       reqForward,
  output dpStrobe_t  strobe,
  output logic       hsValid,
  output logic [1:0] hsCode,
  output stage_t     stage,
  output logic       reqPending,
  output logic       inFlush,
  output logic       statusEvt,
  output logic       statusDir
);
  stage_t stageQ, nStage, tgtQ, nTgt, afterSetup;
  logic   doneQ, nDone;
  logic   nHsV, nFlush, nEvt, nDir;
  hs_t    nHs;

  always_comb begin
    nStage = stageQ;
    nTgt   = tgtQ;
    nDone  = doneQ | swDone;
    nHsV   = 1'b0;
    nHs    = HS_NAK;
    nFlush = 1'b0;
    nEvt   = 1'b0;
    nDir   = 1'b0;
    strobe = '0;
    afterSetup = reqNoData ? ST_STATUS_IN : (reqDirIn ? ST_DATA_IN : ST_DATA_OUT);

    if (stageQ == ST_SETUP_HOLD && swReady) nStage = tgtQ;

    if (tokValid) begin
      if (tokKind == TOK_SETUP) begin
        if (!locked) begin
          strobe.capture = 1'b1;
          nHsV = 1'b1;
          nHs  = HS_ACK;
          if (reqForward) begin
            nStage = ST_SETUP_HOLD;
            nTgt   = afterSetup;
            nDone  = 1'b0;
          end else begin
            nStage = afterSetup;
            nDone  = 1'b1;
            strobe.preRead = 1'b1;
          end
        end
      end else if (tokKind == TOK_IN || tokKind == TOK_OUT) begin
        nHsV = 1'b1;
        unique case (stageQ)
          ST_DATA_IN: begin
            if (tokKind == TOK_IN) nHs = HS_ACK;
            else if (tokZeroLen) begin
              nStage = ST_STATUS_OUT;
              nFlush = autoFlushEn;
              if (doneQ) begin nHs = HS_ACK; nStage = ST_IDLE; nEvt = 1'b1; end
            end else begin
              nHs = HS_STALL; nStage = ST_STALLED;
            end
          end
          ST_DATA_OUT: begin
            if (tokKind == TOK_OUT) nHs = HS_ACK;
            else begin
              nStage = ST_STATUS_IN;
              if (doneQ) begin nHs = HS_ACK; nStage = ST_IDLE; nEvt = 1'b1; nDir = 1'b1; end
            end
          end
          ST_STATUS_IN: begin
            if (tokKind == TOK_IN) begin
              if (doneQ) begin nHs = HS_ACK; nStage = ST_IDLE; nEvt = 1'b1; nDir = 1'b1; end
            end else begin
              nHs = HS_STALL; nStage = ST_STALLED;
            end
          end
          ST_STATUS_OUT: begin
            if (tokKind == TOK_OUT && tokZeroLen) begin
              if (doneQ) begin nHs = HS_ACK; nStage = ST_IDLE; nEvt = 1'b1; end
            end else begin
              nHs = HS_STALL; nStage = ST_STALLED;
            end
          end
          ST_STALLED: nHs = HS_STALL;
          default:    nHs = HS_NAK;   // idle and hold
        endcase
      end
    end

    if (swStall && stageQ != ST_IDLE && !strobe.capture) nStage = ST_STALLED;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageQ    <= ST_IDLE;
      tgtQ      <= ST_IDLE;
      doneQ     <= 1'b1;
      hsValid   <= 1'b0;
      hsCode    <= HS_NAK;
      inFlush   <= 1'b0;
      statusEvt <= 1'b0;
      statusDir <= 1'b0;
    end else begin
      stageQ    <= nStage;
      tgtQ      <= nTgt;
      doneQ     <= nDone;
      hsValid   <= nHsV;
      hsCode    <= nHs;
      inFlush   <= nFlush;
      statusEvt <= nEvt;
      statusDir <= nDir;
    end
  end

  assign stage      = stageQ;
  assign reqPending = !doneQ && stageQ != ST_IDLE && stageQ != ST_STALLED;

  AST_LOCKED_SETUP_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (tokValid && tokKind == TOK_SETUP && locked) |=> !hsValid) else $error("locked setup answered"); // R3
  AST_HOLD_NAKS: assert property (@(posedge clk) disable iff (!rstN)
    (stageQ == ST_SETUP_HOLD && tokValid && tokKind != TOK_SETUP) |=> (hsValid && hsCode == HS_NAK)) else $error("hold not nak"); // R5
  AST_STALLED_STALLS: assert property (@(posedge clk) disable iff (!rstN)
    (stageQ == ST_STALLED && tokValid && tokKind != TOK_SETUP) |=> (hsValid && hsCode == HS_STALL)) else $error("stalled not stall"); // R8
  AST_FLUSH_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(inFlush) |-> $past(autoFlushEn)) else $error("flush without enable"); // R9
  AST_STATUS_WITH_ACK: assert property (@(posedge clk) disable iff (!rstN)
    statusEvt |-> (hsValid && hsCode == HS_ACK && stageQ == ST_IDLE)) else $error("status event without ack"); // R7
endmodule

// File: rtl/ep0_ctrl_seq.sv
module ep0_ctrl_seq
  import ep0_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        tokValid,
  input  logic [1:0]  tokKind,
  input  logic        tokZeroLen,
  input  logic [63:0] setupData,
  input  logic        rdValid,
  input  logic [1:0]  rdIdx,
  output logic [15:0] rdData,
  input  logic        swReady,
  input  logic        swDone,
  input  logic        swStall,
  input  logic        autoFlushEn,
  output logic        hsValid,
  output logic [1:0]  hsCode,
  output logic [2:0]  stage,
  output logic        reqPending,
  output logic        inFlush,
  output logic        statusEvt,
  output logic        statusDir
);
  dpStrobe_t strobe;
  stage_t    stageInt;
  logic      locked, reqDirIn, reqNoData, reqForward;

  ep0_setup_store #(.WORD_W(16), .NUM_WORDS(4)) u_store (
    .clk(clk), .rstN(rstN), .strobe(strobe), .setupData(setupData),
    .rdValid(rdValid), .rdIdx(rdIdx), .rdData(rdData), .locked(locked),
    .reqDirIn(reqDirIn), .reqNoData(reqNoData), .reqForward(reqForward)
  );

  ep0_stage_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .tokValid(tokValid), .tokKind(tokKind),
    .tokZeroLen(tokZeroLen), .swReady(swReady), .swDone(swDone),
    .swStall(swStall), .autoFlushEn(autoFlushEn), .locked(locked),
    .reqDirIn(reqDirIn), .reqNoData(reqNoData), .reqForward(reqForward),
    .strobe(strobe), .hsValid(hsValid), .hsCode(hsCode), .stage(stageInt),
    .reqPending(reqPending), .inFlush(inFlush), .statusEvt(statusEvt),
    .statusDir(statusDir)
  );

  assign stage = stageInt;
endmodule

// File: tb/ep0_ctrl_seq_tb.sv
module ep0_ctrl_seq_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tokValid = 1'b0;
  logic [1:0]  tokKind = 2'd0;
  logic        tokZeroLen = 1'b0;
  logic [63:0] setupData = '0;
  logic        rdValid = 1'b0;
  logic [1:0]  rdIdx = 2'd0;
  logic [15:0] rdData;
  logic        swReady = 1'b0, swDone = 1'b0, swStall = 1'b0, autoFlushEn = 1'b0;
  logic        hsValid, reqPending, inFlush, statusEvt, statusDir;
  logic [1:0]  hsCode;
  logic [2:0]  stage;

  int nChecks = 0;
  int nFails  = 0;

  localparam logic [63:0] GET_DESC  = 64'h0012_0000_0100_0680;
  localparam logic [63:0] VEND_OUT  = 64'h0008_0000_0000_0140;
  localparam logic [63:0] SET_ADDR  = 64'h0000_0000_0005_0500;

  ep0_ctrl_seq u_dut (
    .clk(clk), .rstN(rstN), .tokValid(tokValid), .tokKind(tokKind),
    .tokZeroLen(tokZeroLen), .setupData(setupData), .rdValid(rdValid),
    .rdIdx(rdIdx), .rdData(rdData), .swReady(swReady), .swDone(swDone),
    .swStall(swStall), .autoFlushEn(autoFlushEn), .hsValid(hsValid),
    .hsCode(hsCode), .stage(stage), .reqPending(reqPending),
    .inFlush(inFlush), .statusEvt(statusEvt), .statusDir(statusDir)
  );

  always #5 clk = ~clk;

  task automatic check(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // token for one cycle; outputs sampled at the following negedge
  task automatic sendTok(logic [1:0] kind, logic zl, logic [63:0] data);
    @(negedge clk);
    tokValid = 1'b1; tokKind = kind; tokZeroLen = zl; setupData = data;
    @(posedge clk);
    @(negedge clk);
    tokValid = 1'b0; tokZeroLen = 1'b0;
  endtask

  task automatic expectHs(string tag, int valid, int code);
    check({tag, " hsValid"}, int'(hsValid), valid);
    if (valid != 0) check({tag, " hsCode"}, int'(hsCode), code);
  endtask

  task automatic readWord(int idx, output logic [15:0] v);
    @(negedge clk);
    rdValid = 1'b1; rdIdx = 2'(idx);
    #1 v = rdData;
    @(posedge clk);
    @(negedge clk);
    rdValid = 1'b0;
  endtask

  task automatic readAll();
    logic [15:0] v;
    for (int i = 0; i < 4; i++) readWord(i, v);
  endtask

  task automatic pulse(int which);
    @(negedge clk);
    if (which == 0) swReady = 1'b1;
    else if (which == 1) swDone = 1'b1;
    else swStall = 1'b1;
    @(posedge clk);
    @(negedge clk);
    swReady = 1'b0; swDone = 1'b0; swStall = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 stage", int'(stage), 0);
    check("R1 hsValid", int'(hsValid), 0);
    check("R1 reqPending", int'(reqPending), 0);
  endtask

  task automatic t_idle();
    sendTok(2'd1, 1'b0, '0);
    expectHs("R10 idle IN", 1, 1);
    sendTok(2'd2, 1'b0, '0);
    expectHs("R10 idle OUT", 1, 1);
    check("R10 stage", int'(stage), 0);
  endtask

  task automatic t_read_and_lock();
    logic [15:0] v;
    autoFlushEn = 1'b1;
    sendTok(2'd0, 1'b0, GET_DESC);
    expectHs("R2 setup ack", 1, 0);
    check("R4 hold stage", int'(stage), 1);
    check("R4 reqPending", int'(reqPending), 1);
    sendTok(2'd1, 1'b0, '0);
    expectHs("R5 hold IN nak", 1, 1);
    sendTok(2'd0, 1'b0, SET_ADDR);
    expectHs("R3 locked setup silent", 0, 0);
    check("R3 stage kept", int'(stage), 1);
    readWord(0, v); check("R2 word0", int'(v), 16'h0680);
    readWord(1, v); check("R2 word1", int'(v), 16'h0100);
    readWord(2, v); check("R2 word2", int'(v), 16'h0000);
    // last read collides with a new SETUP
    @(negedge clk);
    tokValid = 1'b1; tokKind = 2'd0; setupData = SET_ADDR;
    rdValid = 1'b1; rdIdx = 2'd3;
    #1 v = rdData;
    @(posedge clk);
    @(negedge clk);
    tokValid = 1'b0; rdValid = 1'b0;
    check("R2 word3", int'(v), 16'h0012);
    expectHs("R3 collision setup silent", 0, 0);
    readWord(0, v); check("R3 word0 kept", int'(v), 16'h0680);
    pulse(0);
    check("R5 ready to DATA_IN", int'(stage), 2);
    sendTok(2'd1, 1'b0, '0);
    expectHs("R6 data IN ack", 1, 0);
    sendTok(2'd2, 1'b1, '0);
    expectHs("R7 status OUT nak", 1, 1);
    check("R7 stage STATUS_OUT", int'(stage), 5);
    check("R9 flush pulse", int'(inFlush), 1);
    pulse(1);
    check("R9 flush one cycle", int'(inFlush), 0);
    sendTok(2'd2, 1'b1, '0);
    expectHs("R7 status OUT ack", 1, 0);
    check("R7 statusEvt", int'(statusEvt), 1);
    check("R7 statusDir OUT", int'(statusDir), 0);
    check("R7 back to idle", int'(stage), 0);
    autoFlushEn = 1'b0;
  endtask

  task automatic t_write();
    sendTok(2'd0, 1'b0, VEND_OUT);
    expectHs("R4 vendor ack", 1, 0);
    check("R4 vendor hold", int'(stage), 1);
    readAll();
    sendTok(2'd2, 1'b0, '0);
    expectHs("R5 hold OUT nak", 1, 1);
    pulse(0);
    check("R5 ready to DATA_OUT", int'(stage), 3);
    sendTok(2'd2, 1'b0, '0);
    expectHs("R6 data OUT ack", 1, 0);
    pulse(1);
    check("R4 reqPending cleared", int'(reqPending), 0);
    sendTok(2'd1, 1'b0, '0);
    expectHs("R7 status IN ack", 1, 0);
    check("R7 statusDir IN", int'(statusDir), 1);
    check("R7 idle after write", int'(stage), 0);
  endtask

  task automatic t_internal();
    logic [15:0] v;
    sendTok(2'd0, 1'b0, SET_ADDR);
    expectHs("R4 internal ack", 1, 0);
    check("R4 internal STATUS_IN", int'(stage), 4);
    check("R4 internal no pending", int'(reqPending), 0);
    readWord(1, v); check("R2 addr word1", int'(v), 16'h0005);
    sendTok(2'd1, 1'b0, '0);
    expectHs("R7 internal status ack", 1, 0);
    check("R7 internal evt", int'(statusEvt), 1);
    check("R7 internal idle", int'(stage), 0);
  endtask

  task automatic t_stall();
    sendTok(2'd0, 1'b0, GET_DESC);
    expectHs("R8 setup ack", 1, 0);
    pulse(2);
    check("R8 stalled", int'(stage), 6);
    sendTok(2'd1, 1'b0, '0);
    expectHs("R8 IN stall", 1, 2);
    sendTok(2'd2, 1'b1, '0);
    expectHs("R8 OUT stall", 1, 2);
    sendTok(2'd0, 1'b0, SET_ADDR);
    expectHs("R3 locked in stall silent", 0, 0);
    check("R3 still stalled", int'(stage), 6);
    readAll();
    sendTok(2'd0, 1'b0, SET_ADDR);
    expectHs("R8 setup clears stall", 1, 0);
    check("R8 left stall", int'(stage), 4);
    sendTok(2'd1, 1'b0, '0);
    expectHs("R8 finish", 1, 0);
  endtask

  task automatic t_noflush();
    sendTok(2'd0, 1'b0, GET_DESC);
    readAll();
    pulse(0);
    sendTok(2'd1, 1'b0, '0);
    expectHs("R6 IN ack", 1, 0);
    sendTok(2'd2, 1'b1, '0);
    check("R9 no flush when disabled", int'(inFlush), 0);
    check("R7 STATUS_OUT", int'(stage), 5);
    sendTok(2'd2, 1'b0, '0);
    expectHs("R8 data in status stall", 1, 2);
    check("R8 stalled after data", int'(stage), 6);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle();
    t_read_and_lock();
    t_write();
    t_internal();
    t_stall();
    t_noflush();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule